// File: doc/BRIEF.md
# Asynchronous Byte-Wide Register Bus Bridge

This block sits on the slave side of an 8-bit asynchronous microprocessor bus and gives that bus access to a local register file of byte-wide entries. A strap input chooses, at run time, which of two strobe conventions the shared control pins follow.

- **Split-strobe convention.** The two control pins are separate active-low read and write strobes.
- **Direction-plus-strobe convention.** One pin is a direction line, high for a read. The other pin is an active-low data strobe that qualifies the transfer.

In both conventions nothing happens unless the active-low chip select is low. The address and data buses are separate; they are never multiplexed.

Every bus input, including the strap, first passes through a two-flop synchronizer on the system clock. The control logic then finds strobe edges on the synchronized signals. A write lands in the register file on the clock after the synchronized write qualifier ends. It uses the address and data that were present while the qualifier was last active. During a read the bridge presents the addressed byte and raises an output enable. The pad logic outside this block uses that enable to drive the bus, and leaves the bus high impedance whenever the enable is low.

Top module: `regBusBridge`

## Requirements
- R1: After reset every register entry reads back as 0x00, and `dataOe` is 0.
- R2: With `busMode` = 0, `csN` low, and `wrDir` pulsed low then high, one write occurs. It stores `dataIn` at the address.
- R3: With `busMode` = 0, `csN` low and `rdDsN` low, `dataOe` is 1 and `dataOut` equals the addressed entry. Once `rdDsN` returns high, `dataOe` is 0.
- R4: With `busMode` = 1, `csN` low, `wrDir` = 0 (write direction), and `rdDsN` pulsed low then high, one write occurs. It stores `dataIn` at the address.
- R5: With `busMode` = 1, `csN` low, `wrDir` = 1 (read direction) and `rdDsN` low, `dataOe` is 1 and `dataOut` equals the addressed entry.
- R6: While `csN` is high, strobe activity in either mode writes nothing and leaves `dataOe` at 0.
- R7: The entry index is {`addrHi`, `addrLo`}, a 10-bit value with `addrHi` as bit 9. Indices 0x000, 0x1FF, 0x200 and 0x3FF address four distinct entries.
- R8: A write commits only when the write qualifier ends. It stores the address and data present just before that end; values presented earlier in the same strobe are not used.
- R9: `dataOe` rises on the third rising clock edge after the read qualifier becomes active. It falls on the third rising edge after the qualifier ends.
- R10: With `busMode` = 1 and `rdDsN` held high, toggling `wrDir` causes no write and no read.
- R11: A byte written under one convention reads back unchanged under the other, after `busMode` is changed while `csN` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busMode | input | 1 | Strap: 0 split strobes, 1 direction plus data strobe |
| csN | input | 1 | Active-low chip select |
| rdDsN | input | 1 | Mode 0: active-low read strobe; mode 1: active-low data strobe |
| wrDir | input | 1 | Mode 0: active-low write strobe; mode 1: direction, 1 = read |
| addrLo | input | 9 | Low address lines, index bits 8..0 |
| addrHi | input | 1 | High address line, index bit 9 |
| dataIn | input | 8 | Write data from the bus |
| dataOut | output | 8 | Read data toward the bus |
| dataOe | output | 1 | Read-data output enable; bus tri-stated when 0 |

## Verification
The hardest case to reach is a strobe whose address and data change while it is held active. Only the values present when the strobe ends may be stored, and no earlier value may leak into the register file. The stimulus holds the write strobe low while it changes both the address and the data. It then reads both the first and the last address, and expects only the last one to have changed. A second hard case is the cycle on which the output enable moves, which depends on the synchronizer depth. The bench asserts a read strobe half a clock before an edge and samples the enable just after the second and the third following edges.

// File: rtl/regBusBridgePkg.sv
package regBusBridgePkg;

  typedef enum logic {
    MODE_SPLIT     = 1'b0,
    MODE_DIRSTROBE = 1'b1
  } busMode_e;

  typedef struct packed {
    logic capture;   // write qualifier active: latch address and data
    logic commit;    // write qualifier just ended: store latched byte
    logic readEn;    // read qualifier active
  } ctlStrobes_t;

endpackage

// File: rtl/regBusSync.sv
module regBusSync #(
  parameter int WIDTH = 1,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageOne;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageOne <= RESET_VAL;
      syncOut  <= RESET_VAL;
    end else begin
      stageOne <= asyncIn;
      syncOut  <= stageOne;
    end
  end

endmodule

// File: rtl/regBusControl.sv
module regBusControl
  import regBusBridgePkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        modeS,
  input  logic        csNS,
  input  logic        rdDsNS,
  input  logic        wrDirS,
  output ctlStrobes_t strobes
);

  logic readLvl;
  logic writeLvl;
  logic writeLvlQ;

  always_comb begin
    readLvl  = 1'b0;
    writeLvl = 1'b0;
    if (!csNS) begin
      if (modeS == MODE_DIRSTROBE) begin
        readLvl  = !rdDsNS && wrDirS;
        writeLvl = !rdDsNS && !wrDirS;
      end else begin
        readLvl  = !rdDsNS;
        writeLvl = !wrDirS;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) writeLvlQ <= 1'b0;
    else       writeLvlQ <= writeLvl;
  end

  always_comb begin
    strobes.capture = writeLvl;
    strobes.commit  = writeLvlQ && !writeLvl;
    strobes.readEn  = readLvl;
  end

  AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |=> !strobes.commit); // R8

  AST_WR_NEEDS_CS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |-> !$past(csNS)); // R6

endmodule

// File: rtl/regBusDatapath.sv
module regBusDatapath
  import regBusBridgePkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [ADDR_W-1:0] addrS,
  input  logic [DATA_W-1:0] dataS,
  output logic [DATA_W-1:0] rdData,
  output logic              rdOe
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] regs [DEPTH];
  logic [ADDR_W-1:0] wrAddr;
  logic [DATA_W-1:0] wrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrAddr <= '0;
      wrData <= '0;
    end else if (strobes.capture) begin
      wrAddr <= addrS;
      wrData <= dataS;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (strobes.commit) begin
      regs[wrAddr] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
      rdOe   <= 1'b0;
    end else begin
      rdOe <= strobes.readEn;
      if (strobes.readEn) rdData <= regs[addrS];
    end
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |=> regs[$past(wrAddr)] == $past(wrData)); // R8

endmodule

// File: rtl/regBusBridge.sv
module regBusBridge
  import regBusBridgePkg::*;
#(
  parameter int LO_ADDR_W = 9,
  parameter int DATA_W    = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busMode,
  input  logic                 csN,
  input  logic                 rdDsN,
  input  logic                 wrDir,
  input  logic [LO_ADDR_W-1:0] addrLo,
  input  logic                 addrHi,
  input  logic [DATA_W-1:0]    dataIn,
  output logic [DATA_W-1:0]    dataOut,
  output logic                 dataOe
);

  localparam int ADDR_W = LO_ADDR_W + 1;
  localparam int SYNC_W = 4 + ADDR_W + DATA_W;
  localparam logic [SYNC_W-1:0] SYNC_RST = {1'b0, 1'b1, 1'b1, 1'b1, {(ADDR_W + DATA_W){1'b0}}};

  logic [SYNC_W-1:0] rawBus;
  logic [SYNC_W-1:0] syncBus;
  logic              modeS;
  logic              csNS;
  logic              rdDsNS;
  logic              wrDirS;
  logic [ADDR_W-1:0] addrS;
  logic [DATA_W-1:0] dataS;
  ctlStrobes_t       strobes;

  assign rawBus = {busMode, csN, rdDsN, wrDir, addrHi, addrLo, dataIn};
  assign {modeS, csNS, rdDsNS, wrDirS, addrS, dataS} = syncBus;

  regBusSync #(.WIDTH(SYNC_W), .RESET_VAL(SYNC_RST)) uSync (
    .clk(clk), .rstN(rstN), .asyncIn(rawBus), .syncOut(syncBus)
  );

  regBusControl uCtl (
    .clk(clk), .rstN(rstN), .modeS(modeS), .csNS(csNS),
    .rdDsNS(rdDsNS), .wrDirS(wrDirS), .strobes(strobes)
  );

  regBusDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .addrS(addrS),
    .dataS(dataS), .rdData(dataOut), .rdOe(dataOe)
  );

  AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> !$past(csNS)); // R6

  AST_OE_ENDS_WITH_CS: assert property (@(posedge clk) disable iff (!rstN)
    $past(csNS) && $past(csNS, 2) |-> !dataOe); // R3

endmodule

// File: tb/tb_regBusBridge.sv
`timescale 1ns/1ps
module tb_regBusBridge;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busMode = 1'b0;
  logic       csN = 1'b1;
  logic       rdDsN = 1'b1;
  logic       wrDir = 1'b1;
  logic [8:0] addrLo = '0;
  logic       addrHi = 1'b0;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut;
  logic       dataOe;

  logic [7:0] refMem [1024];
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  regBusBridge dut (
    .clk(clk), .rstN(rstN), .busMode(busMode), .csN(csN), .rdDsN(rdDsN),
    .wrDir(wrDir), .addrLo(addrLo), .addrHi(addrHi), .dataIn(dataIn),
    .dataOut(dataOut), .dataOe(dataOe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic waitNeg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setAddr(input int a);
    addrHi = a[9];
    addrLo = a[8:0];
  endtask

  task automatic setMode(input bit m);
    csN = 1'b1; rdDsN = 1'b1; wrDir = 1'b1;
    waitNeg(4);
    busMode = m;
    waitNeg(4);
  endtask

  task automatic busWrite(input int a, input logic [7:0] d);
    setAddr(a); dataIn = d;
    csN = 1'b0; waitNeg(3);
    if (busMode) begin
      wrDir = 1'b0; waitNeg(3);
      rdDsN = 1'b0; waitNeg(4);
      rdDsN = 1'b1; waitNeg(3);
      wrDir = 1'b1;
    end else begin
      wrDir = 1'b0; waitNeg(4);
      wrDir = 1'b1;
    end
    waitNeg(3);
    csN = 1'b1; waitNeg(4);
    refMem[a] = d;
  endtask

  task automatic busRead(input int a, input string tag);
    setAddr(a);
    csN = 1'b0; wrDir = 1'b1; waitNeg(3);
    rdDsN = 1'b0; waitNeg(5);
    check(dataOe === 1'b1, {tag, " oe during read"}, dataOe, 1);
    check(dataOut === refMem[a], {tag, " read data"}, dataOut, refMem[a]);
    rdDsN = 1'b1; waitNeg(5);
    check(dataOe === 1'b0, {tag, " oe after read"}, dataOe, 0);
    csN = 1'b1; waitNeg(4);
  endtask

  task automatic testReset;
    check(dataOe === 1'b0, "R1 oe after reset", dataOe, 0);
    busRead(0, "R1 entry 0x000");
    busRead(10'h155, "R1 entry 0x155");
    busRead(10'h3FF, "R1 entry 0x3FF");
  endtask

  task automatic testSplitMode;
    setMode(1'b0);
    busWrite(10'h012, 8'hA5);
    busRead(10'h012, "R2 split write");
    busWrite(10'h013, 8'h3C);
    busRead(10'h013, "R3 split read");
    busRead(10'h012, "R3 split read neighbour");
  endtask

  task automatic testDirMode;
    setMode(1'b1);
    busWrite(10'h0C0, 8'h5A);
    busRead(10'h0C0, "R4 dir write");
    busWrite(10'h0C1, 8'hF0);
    busRead(10'h0C1, "R5 dir read");
  endtask

  task automatic testAddrSpan;
    int addrs [4] = '{10'h000, 10'h1FF, 10'h200, 10'h3FF};
    setMode(1'b0);
    for (int i = 0; i < 4; i++) busWrite(addrs[i], 8'h10 + 8'(i));
    for (int i = 0; i < 4; i++) busRead(addrs[i], "R7 address span");
  endtask

  task automatic testCsIgnored;
    bit sawOe;
    setMode(1'b0);
    setAddr(10'h012); dataIn = 8'hEE;
    sawOe = 1'b0;
    wrDir = 1'b0; waitNeg(4); wrDir = 1'b1; waitNeg(4);
    rdDsN = 1'b0;
    for (int i = 0; i < 6; i++) begin
      waitNeg(1);
      if (dataOe) sawOe = 1'b1;
    end
    rdDsN = 1'b1; waitNeg(4);
    check(!sawOe, "R6 split oe with cs high", sawOe, 0);
    busRead(10'h012, "R6 split no write with cs high");
    setMode(1'b1);
    setAddr(10'h0C0); dataIn = 8'h77;
    wrDir = 1'b0; waitNeg(2);
    rdDsN = 1'b0; waitNeg(4); rdDsN = 1'b1; waitNeg(2);
    wrDir = 1'b1; waitNeg(2);
    rdDsN = 1'b0;
    for (int i = 0; i < 6; i++) begin
      waitNeg(1);
      if (dataOe) sawOe = 1'b1;
    end
    rdDsN = 1'b1; waitNeg(4);
    check(!sawOe, "R6 dir oe with cs high", sawOe, 0);
    busRead(10'h0C0, "R6 dir no write with cs high");
  endtask

  task automatic testLateValues;
    setMode(1'b0);
    setAddr(10'h2A0); dataIn = 8'h11;
    csN = 1'b0; waitNeg(3);
    wrDir = 1'b0; waitNeg(4);
    dataIn = 8'h22; waitNeg(3);
    setAddr(10'h2A1); dataIn = 8'h33; waitNeg(4);
    wrDir = 1'b1; waitNeg(3);
    csN = 1'b1; waitNeg(4);
    refMem[10'h2A1] = 8'h33;
    busRead(10'h2A0, "R8 early address untouched");
    busRead(10'h2A1, "R8 last address and data stored");
  endtask

  task automatic testOeLatency;
    setMode(1'b0);
    setAddr(10'h013);
    csN = 1'b0; waitNeg(4);
    rdDsN = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    check(dataOe === 1'b0, "R9 oe low after two edges", dataOe, 0);
    @(posedge clk); #1;
    check(dataOe === 1'b1, "R9 oe high on third edge", dataOe, 1);
    check(dataOut === refMem[10'h013], "R9 data with oe", dataOut, refMem[10'h013]);
    @(negedge clk); rdDsN = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    check(dataOe === 1'b1, "R9 oe still high after two edges", dataOe, 1);
    @(posedge clk); #1;
    check(dataOe === 1'b0, "R9 oe low on third edge", dataOe, 0);
    @(negedge clk); csN = 1'b1; waitNeg(4);
  endtask

  task automatic testDirNoStrobe;
    bit sawOe;
    setMode(1'b1);
    setAddr(10'h0C1); dataIn = 8'h99;
    sawOe = 1'b0;
    csN = 1'b0; waitNeg(3);
    for (int i = 0; i < 4; i++) begin
      wrDir = 1'b0; waitNeg(3);
      if (dataOe) sawOe = 1'b1;
      wrDir = 1'b1; waitNeg(3);
      if (dataOe) sawOe = 1'b1;
    end
    csN = 1'b1; waitNeg(4);
    check(!sawOe, "R10 no read from direction toggles", sawOe, 0);
    busRead(10'h0C1, "R10 no write from direction toggles");
  endtask

  task automatic testCrossMode;
    setMode(1'b0);
    busWrite(10'h345, 8'hC3);
    setMode(1'b1);
    busRead(10'h345, "R11 split write dir read");
    busWrite(10'h346, 8'h69);
    setMode(1'b0);
    busRead(10'h346, "R11 dir write split read");
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) refMem[i] = 8'h00;
    waitNeg(3);
    rstN = 1'b1;
    waitNeg(3);
    testReset();
    testSplitMode();
    testDirMode();
    testAddrSpan();
    testCsIgnored();
    testLateValues();
    testOeLatency();
    testDirNoStrobe();
    testCrossMode();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule